// File: doc/BRIEF.md
# AC-link global reset and interrupt controller

This block holds the global control word of an AC'97-style codec link together with the logic that acts on it. The host writes and reads the word through a simple register port. Its bits set the codec reset pin, start a warm reset, shut the link off, and enable interrupts for codec resume events and general-purpose input changes. A second word, chosen by `reg_sel_i`, holds the sticky event status bits. The host clears them by writing ones.

A warm reset wakes a suspended codec without clearing its registers. The block therefore tracks whether the codec's bit clock is toggling. It accepts a warm-reset command only while that clock is stopped. It then raises SYNC for a fixed number of system clocks and keeps the command bit set until the bit clock has been seen running again. A platform bus reset or entry into a sleep state forces the codec back into cold reset, whatever software has written. While the link is shut off, every link output is held low and the input buffers are disabled.

Top module: `aclink_glob_ctrl`

## Requirements
- R1: The control word changes only on a write with `reg_sel_i`=0 and `reg_be_i`=4'hF. A write with any other byte-enable pattern has no effect. The control bits are: bit 0 = GPI interrupt enable, bit 1 = cold-reset release, bit 2 = warm reset, bit 3 = link shut-off, bit 4 = primary resume enable, bit 5 = secondary resume enable. Bits 31:6 read as zero.
- R2: After `rst_ni`, both words read 0, so `codec_rst_no` starts low. While bit 3 is 0, `codec_rst_no` follows bit 1.
- R3: When `bus_rst_i` or `sleep_enter_i` is high at a clock edge, bit 1 becomes 0. This holds even if a write of 1 to bit 1 happens in the same cycle.
- R4: The bit clock passes through a two-stage synchronizer. The clock counts as running once an edge has been seen within the last WIN_CYCLES system clocks. Otherwise it counts as stopped.
- R5: Writing 1 to bit 2 while the bit clock is stopped starts a warm reset. `sync_o` is then high for exactly SYNC_CYCLES clocks, starting in the cycle after the write. If the clock is running, the write is discarded and bit 2 keeps its value.
- R6: Bit 2 reads 1 from the write until the pulse has ended and the bit clock has been judged running again. It then clears itself. Writing 0 to bit 2 has no effect.
- R7: While bit 3 is 1, `codec_rst_no`, `sync_o` and `sdata_out_o` are low and `sdata_in_en_o` is low. While bit 3 is 0, `sync_o` is `frame_sync_i` ORed with the warm pulse, and `sdata_out_o` follows `sdata_out_i`.
- R8: The status word (`reg_sel_i`=1) has bit 0 = GPI change, bit 1 = primary resume and bit 2 = secondary resume. Each bit is set by its event input whether or not its enable is set. A full-word write of 1 to a bit clears it. If an event and a clear fall in the same cycle, the bit stays set. Bits 31:3 read as zero.
- R9: `irq_o` is high exactly while some status bit and its enable (control bits 0, 4 and 5 respectively) are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_sel_i | input | 1 | 0 = control word, 1 = status word |
| reg_be_i | input | 4 | Byte enables of the write |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data of the selected word |
| bus_rst_i | input | 1 | Platform bus reset, forces codec reset |
| sleep_enter_i | input | 1 | Sleep-state entry, forces codec reset |
| bit_clk_i | input | 1 | Codec bit clock, asynchronous |
| frame_sync_i | input | 1 | Frame SYNC from the frame logic |
| sdata_out_i | input | 1 | Serial data from the frame logic |
| pri_resume_i | input | 1 | Primary codec resume event |
| sec_resume_i | input | 1 | Secondary codec resume event |
| gpi_change_i | input | 1 | GPI change event |
| codec_rst_no | output | 1 | Codec reset pin, active low |
| sync_o | output | 1 | SYNC to the link |
| sdata_out_o | output | 1 | Serial data to the link |
| sdata_in_en_o | output | 1 | Input buffer enable |
| irq_o | output | 1 | Interrupt request |

## Verification
Two pairs of events can land in the same cycle. The first is a software write of 1 to the cold-reset bit together with a forced reset from sleep entry. The second is a status-clear write in the same cycle as a new GPI event. The bench drives each pair in a single cycle. It then checks that the forced reset and the new event take precedence. A behavioural model is compared against the block on every clock. That model also covers warm-reset requests made just after the bit clock stops and just after it restarts.

// File: rtl/aclink_pkg.sv
package aclink_pkg;
  localparam int unsigned REG_W = 32;

  // control word bit positions
  localparam int unsigned C_GPI_IE  = 0;
  localparam int unsigned C_COLD_N  = 1;
  localparam int unsigned C_WARM    = 2;
  localparam int unsigned C_SHUT    = 3;
  localparam int unsigned C_PRI_IE  = 4;
  localparam int unsigned C_SEC_IE  = 5;
  localparam int unsigned CTRL_BITS = 6;

  // status word
  localparam int unsigned STS_BITS = 3;

  typedef enum logic [1:0] {
    WARM_IDLE  = 2'd0,
    WARM_PULSE = 2'd1,
    WARM_WAIT  = 2'd2
  } warm_state_e;
endpackage

// File: rtl/aclink_bclk_mon.sv
module aclink_bclk_mon #(
  parameter int unsigned WIN_CYCLES = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bit_clk_i,
  output logic running_o
);
  localparam int unsigned CNT_W = $clog2(WIN_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(WIN_CYCLES);

  logic [2:0]       sync_q;
  logic [CNT_W-1:0] idle_cnt_q;
  logic             edge_seen;

  assign edge_seen = sync_q[1] ^ sync_q[2];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q     <= '0;
      idle_cnt_q <= CNT_MAX;
    end else begin
      sync_q <= {sync_q[1:0], bit_clk_i};
      if (edge_seen)
        idle_cnt_q <= '0;
      else if (idle_cnt_q != CNT_MAX)
        idle_cnt_q <= idle_cnt_q + 1'b1;
    end
  end

  assign running_o = (idle_cnt_q != CNT_MAX);
endmodule

// File: rtl/aclink_warm_seq.sv
module aclink_warm_seq
  import aclink_pkg::*;
#(
  parameter int unsigned SYNC_CYCLES = 34
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic bclk_run_i,
  output logic busy_o,
  output logic pulse_o
);
  localparam int unsigned CNT_W = (SYNC_CYCLES > 1) ? $clog2(SYNC_CYCLES) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(SYNC_CYCLES - 1);

  warm_state_e      state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    unique case (state_q)
      WARM_IDLE: if (start_i && !bclk_run_i) begin
        state_d = WARM_PULSE;
        cnt_d   = '0;
      end
      WARM_PULSE: begin
        if (cnt_q == LAST) state_d = WARM_WAIT;
        else               cnt_d   = cnt_q + 1'b1;
      end
      WARM_WAIT: if (bclk_run_i) state_d = WARM_IDLE;
      default: state_d = WARM_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= WARM_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  assign busy_o  = (state_q != WARM_IDLE);
  assign pulse_o = (state_q == WARM_PULSE);
endmodule

// File: rtl/aclink_irq_gate.sv
module aclink_irq_gate #(
  parameter int unsigned N_SRC = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_SRC-1:0] set_i,
  input  logic [N_SRC-1:0] clr_i,
  input  logic [N_SRC-1:0] en_i,
  output logic [N_SRC-1:0] sts_o,
  output logic             irq_o
);
  logic [N_SRC-1:0] sts_q;

  for (genvar g = 0; g < N_SRC; g++) begin : g_src
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       sts_q[g] <= 1'b0;
      else if (set_i[g]) sts_q[g] <= 1'b1;  // new event beats clear
      else if (clr_i[g]) sts_q[g] <= 1'b0;
    end
  end

  assign sts_o = sts_q;
  assign irq_o = |(sts_q & en_i);
endmodule

// File: rtl/aclink_glob_ctrl.sv
module aclink_glob_ctrl
  import aclink_pkg::*;
#(
  parameter int unsigned WIN_CYCLES  = 8,
  parameter int unsigned SYNC_CYCLES = 34
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        reg_we_i,
  input  logic        reg_sel_i,
  input  logic [3:0]  reg_be_i,
  input  logic [31:0] reg_wdata_i,
  output logic [31:0] reg_rdata_o,
  input  logic        bus_rst_i,
  input  logic        sleep_enter_i,
  input  logic        bit_clk_i,
  input  logic        frame_sync_i,
  input  logic        sdata_out_i,
  input  logic        pri_resume_i,
  input  logic        sec_resume_i,
  input  logic        gpi_change_i,
  output logic        codec_rst_no,
  output logic        sync_o,
  output logic        sdata_out_o,
  output logic        sdata_in_en_o,
  output logic        irq_o
);
  logic full_wr, ctrl_wr, sts_wr;
  logic gpi_ie_q, cold_n_q, shut_q, pri_ie_q, sec_ie_q;
  logic bclk_run, warm_busy, warm_pulse;
  logic [STS_BITS-1:0] sts, sts_clr, sts_set, sts_en;

  assign full_wr = reg_we_i && (reg_be_i == 4'hF);
  assign ctrl_wr = full_wr && !reg_sel_i;
  assign sts_wr  = full_wr &&  reg_sel_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gpi_ie_q <= 1'b0;
      shut_q   <= 1'b0;
      pri_ie_q <= 1'b0;
      sec_ie_q <= 1'b0;
    end else if (ctrl_wr) begin
      gpi_ie_q <= reg_wdata_i[C_GPI_IE];
      shut_q   <= reg_wdata_i[C_SHUT];
      pri_ie_q <= reg_wdata_i[C_PRI_IE];
      sec_ie_q <= reg_wdata_i[C_SEC_IE];
    end
  end

  // platform reset / sleep override software
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                         cold_n_q <= 1'b0;
    else if (bus_rst_i || sleep_enter_i) cold_n_q <= 1'b0;
    else if (ctrl_wr)                    cold_n_q <= reg_wdata_i[C_COLD_N];
  end

  aclink_bclk_mon #(.WIN_CYCLES(WIN_CYCLES)) i_bclk_mon (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .bit_clk_i (bit_clk_i),
    .running_o (bclk_run)
  );

  aclink_warm_seq #(.SYNC_CYCLES(SYNC_CYCLES)) i_warm_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (ctrl_wr && reg_wdata_i[C_WARM]),
    .bclk_run_i (bclk_run),
    .busy_o     (warm_busy),
    .pulse_o    (warm_pulse)
  );

  assign sts_set = {sec_resume_i, pri_resume_i, gpi_change_i};
  assign sts_clr = sts_wr ? reg_wdata_i[STS_BITS-1:0] : '0;
  assign sts_en  = {sec_ie_q, pri_ie_q, gpi_ie_q};

  aclink_irq_gate #(.N_SRC(STS_BITS)) i_irq_gate (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (sts_set),
    .clr_i  (sts_clr),
    .en_i   (sts_en),
    .sts_o  (sts),
    .irq_o  (irq_o)
  );

  logic [CTRL_BITS-1:0] ctrl_rd;
  always_comb begin
    ctrl_rd           = '0;
    ctrl_rd[C_GPI_IE] = gpi_ie_q;
    ctrl_rd[C_COLD_N] = cold_n_q;
    ctrl_rd[C_WARM]   = warm_busy;
    ctrl_rd[C_SHUT]   = shut_q;
    ctrl_rd[C_PRI_IE] = pri_ie_q;
    ctrl_rd[C_SEC_IE] = sec_ie_q;
  end

  assign reg_rdata_o = reg_sel_i ? {{(REG_W-STS_BITS){1'b0}}, sts}
                                 : {{(REG_W-CTRL_BITS){1'b0}}, ctrl_rd};

  // link shut-off gates every output
  assign codec_rst_no  = cold_n_q && !shut_q;
  assign sync_o        = !shut_q && (warm_pulse || frame_sync_i);
  assign sdata_out_o   = !shut_q && sdata_out_i;
  assign sdata_in_en_o = !shut_q;
endmodule

// File: rtl/aclink_glob_ctrl_chk.sv
module aclink_glob_ctrl_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        reg_we_i,
  input logic        reg_sel_i,
  input logic [3:0]  reg_be_i,
  input logic [31:0] reg_wdata_i,
  input logic        bus_rst_i,
  input logic        sleep_enter_i,
  input logic        codec_rst_no,
  input logic        sync_o,
  input logic        sdata_out_o,
  input logic        sdata_in_en_o,
  input logic        irq_o,
  input logic        frame_sync_i,
  input logic        cold_n_q,
  input logic        shut_q,
  input logic        gpi_ie_q,
  input logic        pri_ie_q,
  input logic        sec_ie_q,
  input logic        warm_busy,
  input logic        bclk_run
);
  // R1
  partial_wr_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && reg_be_i != 4'hF && !bus_rst_i && !sleep_enter_i)
    |=> $stable({gpi_ie_q, cold_n_q, shut_q, pri_ie_q, sec_ie_q}));

  // R3
  forced_cold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_rst_i || sleep_enter_i) |=> !cold_n_q);

  // R5
  warm_rejected_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!warm_busy && bclk_run && reg_we_i && !reg_sel_i && reg_be_i == 4'hF
     && reg_wdata_i[2]) |=> !warm_busy);

  // R5
  sync_source_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sync_o && !frame_sync_i) |-> warm_busy);

  // R7
  shutoff_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shut_q |-> (!codec_rst_no && !sync_o && !sdata_out_o && !sdata_in_en_o));

  // R9
  irq_needs_en_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(gpi_ie_q || pri_ie_q || sec_ie_q) |-> !irq_o);
endmodule

bind aclink_glob_ctrl aclink_glob_ctrl_chk i_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .reg_we_i      (reg_we_i),
  .reg_sel_i     (reg_sel_i),
  .reg_be_i      (reg_be_i),
  .reg_wdata_i   (reg_wdata_i),
  .bus_rst_i     (bus_rst_i),
  .sleep_enter_i (sleep_enter_i),
  .codec_rst_no  (codec_rst_no),
  .sync_o        (sync_o),
  .sdata_out_o   (sdata_out_o),
  .sdata_in_en_o (sdata_in_en_o),
  .irq_o         (irq_o),
  .frame_sync_i  (frame_sync_i),
  .cold_n_q      (cold_n_q),
  .shut_q        (shut_q),
  .gpi_ie_q      (gpi_ie_q),
  .pri_ie_q      (pri_ie_q),
  .sec_ie_q      (sec_ie_q),
  .warm_busy     (warm_busy),
  .bclk_run      (bclk_run)
);

// File: tb/test_aclink_glob_ctrl.sv
module test_aclink_glob_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int WIN = 8;
  localparam int SYNCN = 34;

  logic clk = 0, rst_n = 0;
  logic we = 0, sel = 0, bclk = 0, fsync = 0, sdo = 0;
  logic bus_rst = 0, sleep = 0, pres = 0, sres = 0, gpi = 0;
  logic [3:0] be = 0;
  logic [31:0] wd = 0, rd;
  logic rst_pin, sync, sdo_o, in_en, irq;

  int n_chk = 0, n_fail = 0;
  bit done = 0, bclk_run = 0;
  int bdiv = 0;

  aclink_glob_ctrl i_aclink_glob_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_sel_i(sel), .reg_be_i(be),
    .reg_wdata_i(wd), .reg_rdata_o(rd), .bus_rst_i(bus_rst), .sleep_enter_i(sleep),
    .bit_clk_i(bclk), .frame_sync_i(fsync), .sdata_out_i(sdo),
    .pri_resume_i(pres), .sec_resume_i(sres), .gpi_change_i(gpi),
    .codec_rst_no(rst_pin), .sync_o(sync), .sdata_out_o(sdo_o),
    .sdata_in_en_o(in_en), .irq_o(irq));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // reference model state
  int m_ctrl[6];
  int m_sts[3];
  int m_hist[$];
  int m_idle, m_wstate, m_wcnt; // wstate: 0 idle, 1 pulse, 2 wait

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      foreach (m_ctrl[i]) m_ctrl[i] = 0;
      foreach (m_sts[i]) m_sts[i] = 0;
      m_hist = '{0, 0, 0};
      m_idle = WIN; m_wstate = 0; m_wcnt = 0;
    end else begin
      bit full, running, edge_now;
      int nstate, ncnt;
      full = we && be == 4'hF;
      running = (m_idle < WIN);
      edge_now = (m_hist[1] != m_hist[2]);
      nstate = m_wstate; ncnt = m_wcnt;
      case (m_wstate)
        0: if (full && !sel && wd[2] && !running) begin nstate = 1; ncnt = 0; end
        1: if (m_wcnt == SYNCN - 1) nstate = 2; else ncnt = m_wcnt + 1;
        default: if (running) nstate = 0;
      endcase
      m_wstate = nstate; m_wcnt = ncnt;
      if (edge_now) m_idle = 0; else if (m_idle < WIN) m_idle++;
      m_hist.push_front(int'(bclk)); void'(m_hist.pop_back());
      if (full && !sel) begin
        m_ctrl[0] = wd[0]; m_ctrl[1] = wd[1]; m_ctrl[3] = wd[3];
        m_ctrl[4] = wd[4]; m_ctrl[5] = wd[5];
      end
      if (bus_rst || sleep) m_ctrl[1] = 0;
      for (int i = 0; i < 3; i++)
        if (full && sel && wd[i]) m_sts[i] = 0;
      if (gpi)  m_sts[0] = 1;
      if (pres) m_sts[1] = 1;
      if (sres) m_sts[2] = 1;
    end
  end

  function automatic logic [31:0] m_rdata();
    logic [31:0] r = 0;
    if (sel) begin
      for (int i = 0; i < 3; i++) r[i] = m_sts[i][0];
    end else begin
      r[0] = m_ctrl[0][0]; r[1] = m_ctrl[1][0]; r[2] = (m_wstate != 0);
      r[3] = m_ctrl[3][0]; r[4] = m_ctrl[4][0]; r[5] = m_ctrl[5][0];
    end
    return r;
  endfunction

  always @(negedge clk) if (rst_n && !done) begin
    bit sh;
    sh = m_ctrl[3][0];
    chk("R1/R8 rdata", rd, m_rdata());
    chk("R2 codec_rst_no", 32'(rst_pin), 32'(m_ctrl[1][0] && !sh));
    chk("R5 sync_o", 32'(sync), 32'(!sh && (m_wstate == 1 || fsync)));
    chk("R7 sdata_out_o", 32'(sdo_o), 32'(!sh && sdo));
    chk("R7 sdata_in_en_o", 32'(in_en), 32'(!sh));
    chk("R9 irq_o", 32'(irq), 32'((m_sts[0] && m_ctrl[0]) || (m_sts[1] && m_ctrl[4])
                                   || (m_sts[2] && m_ctrl[5])));
  end

  // bit clock source, edge every 2 system clocks when enabled
  always @(posedge clk) begin
    #1;
    if (bclk_run) begin
      bdiv++;
      if (bdiv == 2) begin bclk = ~bclk; bdiv = 0; end
    end
  end

  task automatic tick(int n = 1);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic wr(bit s, logic [3:0] b, logic [31:0] d);
    tick(); we = 1; sel = s; be = b; wd = d;
    tick(); we = 0; be = 0; wd = 0;
  endtask

  task automatic rd_chk(string tag, bit s, logic [31:0] exp);
    sel = s; @(negedge clk); chk(tag, rd, exp); tick();
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_fail++; n_chk++;
    $display("FAIL watchdog expired");
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    tick(3); rst_n = 1;
    // R2 reset state
    @(negedge clk); chk("R2 reset rdata", rd, 0); chk("R2 reset pin low", 32'(rst_pin), 0);
    tick();
    wr(0, 4'hF, 32'h02);
    rd_chk("R2 cold release", 0, 32'h02);
    chk("R2 pin high", 32'(rst_pin), 1);
    // R1 partial write and reserved bits
    wr(0, 4'h3, 32'h0000_003B);
    rd_chk("R1 partial ignored", 0, 32'h02);
    wr(0, 4'hF, 32'hFFFF_FFC3);
    rd_chk("R1 reserved zero", 0, 32'h03);
    wr(0, 4'hF, 32'h02);
    // R4/R5 warm rejected while clock runs
    bclk_run = 1; tick(12);
    wr(0, 4'hF, 32'h06);
    rd_chk("R5 warm discarded", 0, 32'h02);
    chk("R5 no sync", 32'(sync), 0);
    // R4 stop and wait past window
    bclk_run = 0; tick(14);
    wr(0, 4'hF, 32'h06);
    @(negedge clk); chk("R5 sync starts", 32'(sync), 1); chk("R6 warm set", rd, 32'h06);
    tick(SYNCN + 4);
    @(negedge clk); chk("R5 sync ended", 32'(sync), 0); chk("R6 warm held", rd, 32'h06);
    wr(0, 4'hF, 32'h02);
    rd_chk("R6 write 0 no effect", 0, 32'h06);
    bclk_run = 1; tick(10);
    rd_chk("R6 warm self-clear", 0, 32'h02);
    // R7 shut-off
    fsync = 1; sdo = 1;
    wr(0, 4'hF, 32'h0A);
    @(negedge clk);
    chk("R7 outputs low", {rst_pin, sync, sdo_o, in_en}, 0);
    wr(0, 4'hF, 32'h02);
    @(negedge clk); chk("R7 outputs back", {rst_pin, sync, sdo_o, in_en}, 4'hF);
    fsync = 0; sdo = 0;
    // R3 sleep beats simultaneous write
    tick(); sleep = 1; we = 1; sel = 0; be = 4'hF; wd = 32'h02;
    tick(); sleep = 0; we = 0; be = 0;
    rd_chk("R3 sleep forces cold", 0, 0);
    wr(0, 4'hF, 32'h02);
    tick(); bus_rst = 1; tick(); bus_rst = 0;
    @(negedge clk); chk("R3 bus reset pin", 32'(rst_pin), 0);
    // R8/R9 GPI
    wr(0, 4'hF, 32'h02);
    tick(); gpi = 1; tick(); gpi = 0;
    @(negedge clk); chk("R9 no irq w/o enable", 32'(irq), 0);
    rd_chk("R8 gpi status set", 1, 32'h1);
    wr(0, 4'hF, 32'h03);
    @(negedge clk); chk("R9 gpi irq", 32'(irq), 1);
    tick(); gpi = 1; we = 1; sel = 1; be = 4'hF; wd = 32'h1;
    tick(); gpi = 0; we = 0; be = 0;
    rd_chk("R8 set beats clear", 1, 32'h1);
    wr(1, 4'hF, 32'h1);
    rd_chk("R8 w1c", 1, 32'h0);
    chk("R9 irq drop", 32'(irq), 0);
    // resume sources
    tick(); pres = 1; sres = 1; tick(); pres = 0; sres = 0;
    rd_chk("R8 resume status", 1, 32'h6);
    chk("R9 resume w/o enable", 32'(irq), 0);
    wr(0, 4'hF, 32'h22);
    @(negedge clk); chk("R9 secondary irq", 32'(irq), 1);
    wr(1, 4'hF, 32'h4);
    @(negedge clk); chk("R9 primary not enabled", 32'(irq), 0);
    wr(0, 4'hF, 32'h12);
    @(negedge clk); chk("R9 primary irq", 32'(irq), 1);
    tick(3);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule